// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the start address of the instruction the CPU is about to execute and compares it with four programmable compare addresses. Each channel can be switched on or off by itself. When an enabled channel matches, the block raises an interrupt request before that instruction runs. It also reports the number of the matching channel and the program-counter value that the CPU should push onto the stack. The request has no mask and no priority gate. It fires whatever the global interrupt-enable state or the current priority level is. Its main use is as a hardware breakpoint or a patch hook for code held in read-only memory.

Software loads the compare addresses and the enable bits through a small write port. The enable bits are split across two control words: one holds channels 0 and 1, the other holds channels 2 and 3. The decoder tells the block whether the instruction at the address belongs to the group whose stacked value is the match address plus two. Examples of that group are 16-bit-opcode forms, short immediate forms, multi-register push/pop and short jump/call. All other instructions stack the match address plus one. That value is not an exact return point, so the interrupt handler must fix the return address itself. Fetches from external areas on an 8-bit-wide bus never produce a match.

Top module: `addr_match_unit`

## Requirements
- R1: After reset all compare addresses are zero and all enables are off. Outputs `brk_req`, `brk_chan` and `brk_pc` are zero, and a valid instruction at address 0 raises no request.
- R2: When `nxt_valid` is high and an enabled channel's compare address equals `nxt_addr`, `brk_req` is high in the next cycle and `brk_chan` shows the channel number. In any cycle where `brk_req` is low, `brk_chan` and `brk_pc` are zero.
- R3: A channel whose enable bit is 0 never causes a request, even when its compare address equals `nxt_addr`.
- R4: A request is raised only for a cycle in which `nxt_valid` is high. A cycle with `nxt_valid` low, such as a stall, yields no request in the following cycle, whatever the value of `nxt_addr`.
- R5: When several enabled channels match in the same cycle, the lowest-numbered one is reported in `brk_chan`.
- R6: When `nxt_long` is high in the matching cycle, `brk_pc` equals the match address plus 2, modulo 2^20.
- R7: When `nxt_long` is low in the matching cycle, `brk_pc` equals the match address plus 1, modulo 2^20. For example, 0xFFFFF gives 0x00000.
- R8: When `nxt_ext8` is high, no request is raised for that cycle, even if an enabled channel matches.
- R9: The `cfg_sel` values select the target of a write:
  - Values 0 to 3 write the compare address of channel 0 to 3 from `cfg_wdata[19:0]`.
  - Value 4 writes the enables of channels 0 and 1 from `cfg_wdata` bits 0 and 1.
  - Value 5 writes the enables of channels 2 and 3 from `cfg_wdata` bits 0 and 1.
- R10: A configuration write takes effect for comparisons from the next cycle on. A comparison in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0-3 compare address, 4 enables of ch0/1, 5 enables of ch2/3 |
| cfg_wdata | input | 20 | Write data |
| nxt_valid | input | 1 | Next-instruction address is valid this cycle |
| nxt_addr | input | 20 | Start address of the next instruction |
| nxt_long | input | 1 | Instruction is in the plus-two stacking group |
| nxt_ext8 | input | 1 | Address lies in an external area on an 8-bit bus |
| brk_req | output | 1 | One-cycle interrupt request |
| brk_chan | output | 2 | Number of the matching channel |
| brk_pc | output | 20 | Program-counter value to stack |

## Verification
The assertions assume two things about the inputs. First, the decoder drives `nxt_long` and `nxt_ext8` in the same cycle as `nxt_valid` and `nxt_addr`. Second, the decoder never sends an undefined `cfg_sel` value while `cfg_we` is high. The stimulus holds inputs steady from one falling edge to the next and uses only selector values 0 to 5. A stall is modelled by holding `nxt_valid` low while the address stays the same. Configuration writes and lookups are sometimes placed in the same cycle, to test the old-value rule.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int AMU_ADDR_W = 20;
  localparam int AMU_NUM_CH = 4;
  localparam int AMU_GRP    = 2;

  // Offset added to the match address for the stacked program counter.
  function automatic logic [1:0] amu_pc_step(input logic long_form);
    return long_form ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/amu_cfg_regs.sv
module amu_cfg_regs #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 4,
  parameter int GRP    = 2,
  parameter int SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [ADDR_W-1:0]        wdata,
  output logic [NUM_CH*ADDR_W-1:0] cmp_flat,
  output logic [NUM_CH-1:0]        en
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int ENSEL = NUM_CH + c / GRP;
    localparam int ENBIT = c % GRP;
    logic [ADDR_W-1:0] cmp_q;
    logic              en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
        en_q  <= 1'b0;
      end else if (we) begin
        if (sel == SEL_W'(c))     cmp_q <= wdata;
        if (sel == SEL_W'(ENSEL)) en_q  <= wdata[ENBIT];
      end
    end

    assign cmp_flat[c*ADDR_W +: ADDR_W] = cmp_q;
    assign en[c] = en_q;
  end
endmodule

// File: rtl/amu_channel.sv
module amu_channel #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] cmp,
  input  logic              en,
  input  logic              qual,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = en && qual && (cmp == addr);
endmodule

// File: rtl/amu_prio_pick.sv
module amu_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/amu_ret_calc.sv
module amu_ret_calc #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              long_form,
  output logic [ADDR_W-1:0] pc
);
  function automatic logic [ADDR_W-1:0] ret_value(input logic [ADDR_W-1:0] a,
                                                  input logic lf);
    return a + ADDR_W'(amu_pkg::amu_pc_step(lf));
  endfunction

  assign pc = ret_value(addr, long_form);
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit #(
  parameter int ADDR_W = amu_pkg::AMU_ADDR_W,
  parameter int NUM_CH = amu_pkg::AMU_NUM_CH,
  parameter int GRP    = amu_pkg::AMU_GRP,
  localparam int NGRP  = (NUM_CH + GRP - 1) / GRP,
  localparam int SEL_W = $clog2(NUM_CH + NGRP),
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              nxt_valid,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_long,
  input  logic              nxt_ext8,
  output logic              brk_req,
  output logic [IDX_W-1:0]  brk_chan,
  output logic [ADDR_W-1:0] brk_pc
);
  logic [NUM_CH*ADDR_W-1:0] cmp_flat;
  logic [NUM_CH-1:0]        ch_en;
  logic [NUM_CH-1:0]        hit_vec;
  logic                     qual;
  logic                     hit_any;
  logic [IDX_W-1:0]         hit_idx;
  logic [ADDR_W-1:0]        ret_pc;

  amu_cfg_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .GRP(GRP), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .cmp_flat(cmp_flat), .en(ch_en)
  );

  // 8-bit external areas are excluded from matching.
  assign qual = nxt_valid && !nxt_ext8;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    amu_channel #(.ADDR_W(ADDR_W)) u_ch (
      .cmp(cmp_flat[c*ADDR_W +: ADDR_W]), .en(ch_en[c]), .qual(qual),
      .addr(nxt_addr), .hit(hit_vec[c])
    );
  end

  amu_prio_pick #(.N(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .req(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  amu_ret_calc #(.ADDR_W(ADDR_W)) u_ret (
    .addr(nxt_addr), .long_form(nxt_long), .pc(ret_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_chan <= '0;
      brk_pc   <= '0;
    end else begin
      brk_req  <= hit_any;
      brk_chan <= hit_any ? hit_idx : '0;
      brk_pc   <= hit_any ? ret_pc : '0;
    end
  end
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nxt_valid,
  input logic [ADDR_W-1:0] nxt_addr,
  input logic              nxt_long,
  input logic              nxt_ext8,
  input logic              brk_req,
  input logic [IDX_W-1:0]  brk_chan,
  input logic [ADDR_W-1:0] brk_pc,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] hit_vec
);
  logic [NUM_CH-1:0] en_d;
  logic [NUM_CH-1:0] hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= '0;
      hit_d <= '0;
    end else begin
      en_d  <= ch_en;
      hit_d <= hit_vec;
    end
  end

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> (brk_chan == '0 && brk_pc == '0));

  p_chan_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> en_d[brk_chan]);

  p_need_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_valid |=> !brk_req);

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (hit_d[brk_chan] &&
                 ((hit_d & ((NUM_CH'(1) << brk_chan) - NUM_CH'(1))) == '0)));

  p_long_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid && nxt_long |=> (!brk_req || brk_pc == ADDR_W'($past(nxt_addr) + 2)));

  p_short_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid && !nxt_long |=> (!brk_req || brk_pc == ADDR_W'($past(nxt_addr) + 1)));

  p_ext8_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_ext8 |=> !brk_req);
endmodule

bind addr_match_unit amu_checker #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
  .nxt_long(nxt_long), .nxt_ext8(nxt_ext8), .brk_req(brk_req),
  .brk_chan(brk_chan), .brk_pc(brk_pc), .ch_en(ch_en), .hit_vec(hit_vec)
);

// File: tb/sim_addr_match_unit.sv
module sim_addr_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic        nxt_valid = 1'b0;
  logic [19:0] nxt_addr = '0;
  logic        nxt_long = 1'b0;
  logic        nxt_ext8 = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_chan;
  logic [19:0] brk_pc;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic        req;
    logic [1:0]  ch;
    logic [19:0] pc;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [19:0] m_cmp [4];
  logic [3:0]  m_en;

  addr_match_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
    .nxt_long(nxt_long), .nxt_ext8(nxt_ext8), .brk_req(brk_req),
    .brk_chan(brk_chan), .brk_pc(brk_pc)
  );

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares the scoreboard head when its due cycle arrives.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (brk_req !== e.req || brk_chan !== e.ch || brk_pc !== e.pc) begin
        bad++;
        $display("FAIL %s: got req=%0b ch=%0d pc=%05h, expected req=%0b ch=%0d pc=%05h",
                 e.tag, brk_req, brk_chan, brk_pc, e.req, e.ch, e.pc);
      end
    end
  end

  // Driver: one cycle of stimulus, expectation computed from the bench's own model.
  task automatic drive(input bit we, input logic [2:0] sel, input logic [19:0] wd,
                       input bit v, input logic [19:0] a, input bit lg, input bit x8,
                       input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    nxt_valid = v; nxt_addr = a; nxt_long = lg; nxt_ext8 = x8;
    e.req = 1'b0; e.ch = 2'd0; e.pc = 20'd0; e.due = cyc + 1; e.tag = tag;
    if (v && !x8) begin
      for (int c = 3; c >= 0; c--) begin
        if (m_en[c] && m_cmp[c] == a) begin
          e.req = 1'b1;
          e.ch  = 2'(c);
        end
      end
      if (e.req) e.pc = lg ? a + 20'd2 : a + 20'd1;
    end
    sb.push_back(e);
    if (we) begin
      if (sel < 3'd4) m_cmp[sel[1:0]] = wd;
      else if (sel == 3'd4) m_en[1:0] = wd[1:0];
      else if (sel == 3'd5) m_en[3:2] = wd[1:0];
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [19:0] wd);
    drive(1'b1, sel, wd, 1'b0, 20'h0, 1'b0, 1'b0, "R9 write cycle");
  endtask

  task automatic look(input logic [19:0] a, input bit lg, input bit x8, input string tag);
    drive(1'b0, 3'd0, 20'h0, 1'b1, a, lg, x8, tag);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) m_cmp[c] = '0;
    m_en = '0;
    repeat (3) @(negedge clk);
    total++;
    if (brk_req !== 1'b0 || brk_chan !== 2'd0 || brk_pc !== 20'd0) begin
      bad++;
      $display("FAIL R1 reset outputs: got %0b/%0d/%05h, expected 0/0/00000",
               brk_req, brk_chan, brk_pc);
    end
    rst_n = 1'b1;
    look(20'h00000, 1'b0, 1'b0, "R1 disabled after reset");

    wr(3'd0, 20'h12345);
    wr(3'd4, 20'h00001);
    look(20'h12345, 1'b0, 1'b0, "R2 R7 basic match short");
    look(20'h12345, 1'b1, 1'b0, "R6 long form");
    look(20'h12346, 1'b0, 1'b0, "R2 no match on neighbour");
    drive(1'b0, 3'd0, 20'h0, 1'b0, 20'h12345, 1'b1, 1'b0, "R4 stall no request");
    look(20'h12345, 1'b0, 1'b1, "R8 ext8 area blocked");

    wr(3'd1, 20'h00400);
    look(20'h00400, 1'b0, 1'b0, "R3 ch1 disabled");
    wr(3'd2, 20'h00400);
    wr(3'd3, 20'h00400);
    wr(3'd5, 20'h00002);
    look(20'h00400, 1'b1, 1'b0, "R9 enable word 2 bit1 is ch3");
    wr(3'd5, 20'h00003);
    look(20'h00400, 1'b0, 1'b0, "R5 ch2 beats ch3");
    wr(3'd4, 20'h00003);
    look(20'h00400, 1'b1, 1'b0, "R5 ch1 beats ch2 ch3");
    wr(3'd4, 20'h00000);
    look(20'h12345, 1'b0, 1'b0, "R3 ch0 disabled again");

    wr(3'd0, 20'hFFFFF);
    wr(3'd4, 20'h00001);
    look(20'hFFFFF, 1'b1, 1'b0, "R6 wrap long");
    look(20'hFFFFF, 1'b0, 1'b0, "R7 wrap short");

    // R10: the write and the lookup share a cycle; the old value applies.
    drive(1'b1, 3'd0, 20'h0ABCD, 1'b1, 20'hFFFFF, 1'b0, 1'b0, "R10 old compare used");
    look(20'hFFFFF, 1'b0, 1'b0, "R10 new compare in force");
    look(20'h0ABCD, 1'b0, 1'b0, "R10 new compare matches");
    drive(1'b1, 3'd4, 20'h0, 1'b1, 20'h0ABCD, 1'b1, 1'b0, "R10 enable cleared same cycle");
    look(20'h0ABCD, 1'b1, 1'b0, "R10 R3 cleared enable in force");

    // Mixed sweep over all channels with varied flags.
    wr(3'd4, 20'h00003);
    wr(3'd5, 20'h00003);
    wr(3'd0, 20'h10000);
    wr(3'd1, 20'h20000);
    wr(3'd2, 20'h30000);
    wr(3'd3, 20'h40000);
    for (int k = 0; k < 24; k++) begin
      logic [19:0] a;
      a = 20'((k % 5) * 20'h10000);
      drive(1'b0, 3'd0, 20'h0, (k % 7) != 3, a, k[0], (k % 6) == 5, "R2 R4 R8 sweep");
    end
    look(20'h20000, 1'b0, 1'b0, "R2 back-to-back 1");
    look(20'h20000, 1'b0, 1'b0, "R2 back-to-back 2");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule